// File: doc/BRIEF.md
# ADC Result Ring Buffer

This block stores conversion results from an ADC sequencing engine in a ring of sixteen slots and gives them back to software one by one through a register-style read port. On the write side the engine presents one result per strobe. Each result lands in the slot chosen by a write pointer. The pointer moves to the next slot after every stored result and wraps from the top slot back to slot 0. A software-issued sequence start loads the pointer from a programmable base slot. The slot that received the latest result is shown on a status output.

The engine also pulses a restart input each time it begins the next sequence of a run. The block treats this restart according to the sequencing mode. In single-sequence mode the restart reloads the base slot, so every sequence overwrites the same window. In continuous mode the pointer ignores the restart, and successive sequences fill consecutive slots around the ring.

On the read side, each read strobe captures the slot named by the read index into a held data register. The read index then advances by one, so repeated reads walk through successive results. Software can also load the read index directly through a separate write strobe.

Top module: `adc_result_ring`

## Requirements
- R1: After reset, `rd_idx`, `last_wr` and `rd_data` are 0. A result stored before any sequence start goes to slot 0.
- R2: A cycle with `rd_strobe` high makes `rd_data` show, from the next cycle, the slot named by `rd_idx` in that cycle. Without `rd_strobe`, `rd_data` holds its value.
- R3: Each read without `idx_wr` increments `rd_idx` by one, wrapping from 15 to 0. Without a read or an index write, `rd_idx` does not change.
- R4: `idx_wr` loads `rd_idx` with `idx_wdata` in the next cycle and takes precedence over the increment. A read in the same cycle uses the old index.
- R5: `seq_start` loads the write pointer from `base_idx`. A result strobed in the same cycle as `seq_start` is stored in slot `base_idx`.
- R6: Each `res_valid` stores `res_data` in the slot named by the write pointer and advances the pointer by one, wrapping from 15 to 0. From the next cycle, `last_wr` shows that slot number.
- R7: With `cont_mode` = 1, `seq_restart` leaves the write pointer unchanged. With base 0 and seven results per sequence, three sequences fill slots 0–6, then 7–13, then 14, 15 and 0–4.
- R8: With `cont_mode` = 0, `seq_restart` reloads the write pointer from `base_idx`. A result in the same cycle is stored in slot `base_idx`.
- R9: If a result is written to the slot being read in the same cycle, `rd_data` returns the slot's previous contents. The new value is seen by a later read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_start | input | 1 | Software sequence start; loads the write pointer from the base slot |
| seq_restart | input | 1 | Engine begins the next sequence of a run |
| cont_mode | input | 1 | 1 = continuous sequencing, 0 = single sequence |
| base_idx | input | 4 | Base slot for the first result of a sequence |
| res_valid | input | 1 | Result strobe |
| res_data | input | 12 | Conversion result |
| rd_strobe | input | 1 | Data read strobe |
| rd_data | output | 12 | Held result from the last read |
| idx_wr | input | 1 | Read index write strobe |
| idx_wdata | input | 4 | New read index value |
| rd_idx | output | 4 | Current read index |
| last_wr | output | 4 | Slot of the most recently stored result |

## Verification
Every result of this block is one register away from its stimulus. The `last_wr`, `rd_idx` and `rd_data` outputs all change at the first rising edge after the strobe. Stored contents can be seen only through a later read, which shows up one edge after that read's strobe. The bench drives each strobe on a falling edge and drops it on the next falling edge. It compares the outputs there, half a period after the single edge that produced them. It predicts slots and data from the arithmetic of the requirements, not from the design.

// File: rtl/adc_ring_pkg.sv
package adc_ring_pkg;
   localparam int RING_IDX_W_DEF  = 4;
   localparam int RING_DATA_W_DEF = 12;

   typedef enum logic {
      SEQ_SINGLE = 1'b0,
      SEQ_CONT   = 1'b1
   } seq_mode_e;
endpackage

// File: rtl/ring_wr_ptr.sv
module ring_wr_ptr
   import adc_ring_pkg::*;
#(
   parameter int IDX_W = RING_IDX_W_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             seq_start,
   input  logic             seq_restart,
   input  logic             cont_mode,
   input  logic [IDX_W-1:0] base_idx,
   input  logic             res_valid,
   output logic             wr_en,
   output logic [IDX_W-1:0] wr_slot,
   output logic [IDX_W-1:0] last_wr
);
   localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

   generate
      if (IDX_W < 1) begin : g_bad_idx
         $error("ring_wr_ptr: IDX_W must be at least 1");
      end
   endgenerate

   seq_mode_e        mode;
   logic             reload;
   logic [IDX_W-1:0] wp_q;

   assign mode    = seq_mode_e'(cont_mode);
   assign reload  = seq_start | (seq_restart & (mode == SEQ_SINGLE));
   assign wr_slot = reload ? base_idx : wp_q;
   assign wr_en   = res_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q    <= '0;
         last_wr <= '0;
      end else begin
         if (res_valid) begin
            wp_q    <= wr_slot + ONE;
            last_wr <= wr_slot;
         end else if (reload) begin
            wp_q    <= base_idx;
         end
      end
   end

   assert_last_follows_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> (last_wr + ONE) == wp_q);

   assert_cont_keeps_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_restart && cont_mode && !seq_start && !res_valid) |=> $stable(wp_q));

   assert_start_loads_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_start && !res_valid) |=> wp_q == $past(base_idx));

   assert_single_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_restart && !cont_mode && res_valid) |=> last_wr == $past(base_idx));
endmodule

// File: rtl/ring_rd_idx.sv
module ring_rd_idx
   import adc_ring_pkg::*;
#(
   parameter int IDX_W = RING_IDX_W_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_strobe,
   input  logic             idx_wr,
   input  logic [IDX_W-1:0] idx_wdata,
   output logic [IDX_W-1:0] rd_idx
);
   localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

   generate
      if (IDX_W < 1) begin : g_bad_idx
         $error("ring_rd_idx: IDX_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rd_idx <= '0;
      else if (idx_wr)    rd_idx <= idx_wdata;
      else if (rd_strobe) rd_idx <= rd_idx + ONE;
   end

   assert_idx_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && !idx_wr) |=> rd_idx == $past(rd_idx) + ONE);

   assert_idx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_strobe && !idx_wr) |=> $stable(rd_idx));

   assert_idx_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      idx_wr |=> rd_idx == $past(idx_wdata));
endmodule

// File: rtl/ring_store.sv
module ring_store
   import adc_ring_pkg::*;
#(
   parameter int DATA_W = RING_DATA_W_DEF,
   parameter int IDX_W  = RING_IDX_W_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_slot,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  rd_slot,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << IDX_W;

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("ring_store: DATA_W must be at least 1");
      end
      if (IDX_W > 8) begin : g_too_deep
         $error("ring_store: IDX_W above 8 makes an oversized register ring");
      end
   endgenerate

   logic [DATA_W-1:0] ent [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_ent
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ent[i] <= '0;
            else if (wr_en && (wr_slot == IDX_W'(i)))
               ent[i] <= wr_data;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= ent[rd_slot];
   end

   assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

   assert_rd_old_on_clash_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && wr_en && (rd_slot == wr_slot) && (wr_data != ent[rd_slot]))
      |=> rd_data != $past(wr_data));
endmodule

// File: rtl/adc_result_ring.sv
module adc_result_ring
   import adc_ring_pkg::*;
#(
   parameter int DATA_W = RING_DATA_W_DEF,
   parameter int IDX_W  = RING_IDX_W_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              seq_start,
   input  logic              seq_restart,
   input  logic              cont_mode,
   input  logic [IDX_W-1:0]  base_idx,
   input  logic              res_valid,
   input  logic [DATA_W-1:0] res_data,
   input  logic              rd_strobe,
   output logic [DATA_W-1:0] rd_data,
   input  logic              idx_wr,
   input  logic [IDX_W-1:0]  idx_wdata,
   output logic [IDX_W-1:0]  rd_idx,
   output logic [IDX_W-1:0]  last_wr
);
   logic             wr_en;
   logic [IDX_W-1:0] wr_slot;

   ring_wr_ptr #(.IDX_W(IDX_W)) u_wr (
      .clk(clk), .rst_n(rst_n),
      .seq_start(seq_start), .seq_restart(seq_restart), .cont_mode(cont_mode),
      .base_idx(base_idx), .res_valid(res_valid),
      .wr_en(wr_en), .wr_slot(wr_slot), .last_wr(last_wr)
   );

   ring_rd_idx #(.IDX_W(IDX_W)) u_rd (
      .clk(clk), .rst_n(rst_n),
      .rd_strobe(rd_strobe), .idx_wr(idx_wr), .idx_wdata(idx_wdata),
      .rd_idx(rd_idx)
   );

   ring_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mem (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_slot(wr_slot), .wr_data(res_data),
      .rd_en(rd_strobe), .rd_slot(rd_idx), .rd_data(rd_data)
   );

   assert_reset_clear_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (rd_idx == '0 && last_wr == '0 && rd_data == '0));
endmodule

// File: tb/sim_adc_result_ring.sv
`timescale 1ns/1ps
module sim_adc_result_ring;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic seq_start = 0, seq_restart = 0, cont_mode = 0, res_valid = 0;
   logic rd_strobe = 0, idx_wr = 0;
   logic [3:0] base_idx = 0, idx_wdata = 0;
   logic [11:0] res_data = 0;
   logic [11:0] rd_data;
   logic [3:0] rd_idx, last_wr;

   int tests = 0, fails = 0;
   logic [11:0] model [16];
   logic [3:0] m_wp = 0, m_ri = 0;
   logic [11:0] held;
   int k = 0;

   always #2.5 clk = ~clk;

   adc_result_ring u0 (
      .clk(clk), .rst_n(rst_n), .seq_start(seq_start), .seq_restart(seq_restart),
      .cont_mode(cont_mode), .base_idx(base_idx), .res_valid(res_valid),
      .res_data(res_data), .rd_strobe(rd_strobe), .rd_data(rd_data),
      .idx_wr(idx_wr), .idx_wdata(idx_wdata), .rd_idx(rd_idx), .last_wr(last_wr)
   );

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [11:0] pat(input int n);
      return 12'((n * 37 + 5) % 4096);
   endfunction

   // one result; st = seq_start, rs = seq_restart in the same cycle
   task automatic push(input bit st, input bit rs, input string req);
      logic [3:0] slot;
      slot = (st || (rs && !cont_mode)) ? base_idx : m_wp;
      res_data = pat(k); res_valid = 1; seq_start = st; seq_restart = rs;
      @(negedge clk);
      res_valid = 0; seq_start = 0; seq_restart = 0;
      model[slot] = pat(k); k++;
      m_wp = slot + 4'd1;
      chk(req, last_wr, slot);
   endtask

   task automatic rd(input string req);
      rd_strobe = 1;
      @(negedge clk);
      rd_strobe = 0;
      chk(req, rd_data, model[m_ri]);
      m_ri = m_ri + 4'd1;
      chk("R3", rd_idx, m_ri);
   endtask

   task automatic set_idx(input logic [3:0] v);
      idx_wr = 1; idx_wdata = v;
      @(negedge clk);
      idx_wr = 0;
      m_ri = v;
      chk("R4", rd_idx, v);
   endtask

   initial begin
      #200000;
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) model[i] = 0;
      repeat (3) @(negedge clk);
      chk("R1", rd_idx, 0); chk("R1", last_wr, 0); chk("R1", rd_data, 0);
      rst_n = 1;
      @(negedge clk);
      chk("R1", rd_idx, 0); chk("R1", last_wr, 0);
      // first result with no start goes to slot 0 (R1)
      push(0, 0, "R1");
      rd("R2");

      // R5/R6: sweep every base, three results each, covers wrap
      for (int b = 0; b < 16; b++) begin
         base_idx = 4'(b);
         push(1, 0, "R5");
         push(0, 0, "R6");
         push(0, 0, "R6");
      end
      // start without result, then results
      base_idx = 4'd9;
      seq_start = 1; @(negedge clk); seq_start = 0; m_wp = 9;
      push(0, 0, "R5");

      // fill whole ring, read it all back plus wrap
      base_idx = 0;
      push(1, 0, "R6");
      for (int i = 1; i < 16; i++) push(0, 0, "R6");
      set_idx(0);
      for (int i = 0; i < 17; i++) rd("R2");

      // R7: continuous mode, 3 sequences of 7 from base 0
      cont_mode = 1; base_idx = 0;
      for (int s = 0; s < 3; s++)
         for (int j = 0; j < 7; j++)
            push(j == 0 && s == 0, j == 0 && s != 0, "R7");
      chk("R7", last_wr, 4);
      set_idx(14);
      for (int i = 0; i < 7; i++) rd("R7");

      // R8: single mode, restarts reload base 3
      cont_mode = 0; base_idx = 3;
      for (int s = 0; s < 3; s++)
         for (int j = 0; j < 7; j++)
            push(j == 0 && s == 0, j == 0 && s != 0, "R8");
      chk("R8", last_wr, 9);
      seq_restart = 1; @(negedge clk); seq_restart = 0; m_wp = 3;
      push(0, 0, "R8");
      set_idx(3);
      for (int i = 0; i < 7; i++) rd("R8");

      // R4: index write and read in same cycle
      set_idx(5);
      idx_wr = 1; idx_wdata = 4'd12; rd_strobe = 1;
      @(negedge clk);
      idx_wr = 0; rd_strobe = 0;
      chk("R4", rd_data, model[5]);
      chk("R4", rd_idx, 12);
      m_ri = 12;

      // R9: write and read the same slot in the same cycle
      set_idx(6);
      held = model[6];
      base_idx = 6; res_data = 12'hABC; res_valid = 1; seq_start = 1; rd_strobe = 1;
      @(negedge clk);
      res_valid = 0; seq_start = 0; rd_strobe = 0;
      chk("R9", rd_data, held);
      model[6] = 12'hABC; m_wp = 7; m_ri = 7;
      chk("R9", last_wr, 6);
      set_idx(6);
      rd("R9");

      // R2: no read leaves rd_data held across writes
      held = rd_data;
      push(0, 0, "R6");
      repeat (3) @(negedge clk);
      chk("R2", rd_data, held);
      chk("R3", rd_idx, m_ri);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule